// File: doc/BRIEF.md
# Lamp Ballast Start-Up Mode Sequencer

This block steps a fluorescent-lamp ballast through its start-up and protection modes. Once the supply is good, an internal ramp counter climbs slowly while the lamp filaments warm up. It then climbs six times faster while the drive frequency sweeps down toward the run value to strike the lamp. After that it settles into a running state and then into an adaptive dead-time (ZVS) regulation state. The ramp counter takes the place of an external timing capacitor. The mode is chosen from thresholds on that one ramp value, whose slope and meaning change as the sequence advances.

The outputs feed an oscillator (a frequency control word), a dead-time generator (a select code) and the gate drivers (a drive-enable level). The block holds two sticky records: that ignition has finished, and that a shutdown has occurred. Both records, and the ramp, clear only when the supply-good level falls.

Ramp scale: 1 LSB stands for about 8 mV. The default thresholds are:

| Threshold | Ramp count | Voltage |
|---|---|---|
| Shutdown | 250 | 2 V |
| Ignition start | 375 | 3 V |
| Run | 625 | 5 V |
| ZVS enable | 750 | 6 V |

Top module: `ballast_startup_seq`

## Requirements
- R1: While reset is high, and whenever supply_ok is low, the following hold one cycle later: mode_o = 5'b00000, drive_en_o = 0, freq_word_o = 0 and dead_sel_o = all ones (maximum). mode_o never has more than one bit set.
- R2: Preheat is mode_o bit 0. After supply_ok rises, the ramp starts at zero and gains 1 count per prescaler tick (one tick every PRESCALE cycles). While the ramp is below the ignition threshold, mode_o shows preheat, freq_word_o = F_RUN*8/5 and dead_sel_o is maximum. Preheat is shown for exactly TH_IGN*PRESCALE cycles.
- R3: Ignition is mode_o bit 1. From the ignition threshold, the ramp gains IGN_MULT counts per tick, clamped at the run threshold. Ignition is shown for ceil((TH_RUN-TH_IGN)/IGN_MULT)*PRESCALE+1 cycles.
- R4: During ignition, freq_word_o = F_RUN + floor(3*F_RUN*(TH_RUN-ramp)/(5*(TH_RUN-TH_IGN))). This gives 1.6*F_RUN at the ignition threshold and F_RUN at the run threshold.
- R5: Run is mode_o bit 2. Once ignition ends, the ramp gains 1 count per tick up to the ZVS threshold. Run is shown for (TH_ZVS-TH_RUN)*PRESCALE cycles, with freq_word_o = F_RUN.
- R6: Active ZVS is mode_o bit 3. It is entered after the ramp reaches the ZVS threshold. freq_word_o stays F_RUN and the ramp keeps climbing 1 count per tick, saturating at full scale.
- R7: In ignition, run and active ZVS, dead_sel_o = max(0, DT_MAX - floor((ramp-TH_IGN)/DT_STEP)) for ramp at or above TH_IGN, and DT_MAX below it. DT_MAX = 2^DT_W-1. A falling ramp therefore lengthens the dead time.
- R8: Once ignition has finished, preheat and ignition are not shown again until supply_ok falls. This holds even if the ramp is pulled back between the ignition and run thresholds.
- R9: Shutdown is mode_o bit 4. In active ZVS, ext_shutdown clears the ramp. zvs_pulldown lowers the ramp 1 count per tick. A ramp below TH_SHUT enters shutdown. In shutdown, drive_en_o = 0 and freq_word_o = 0, and the state stays latched while supply_ok is high.
- R10: ext_shutdown and zvs_pulldown have no effect before active ZVS is entered. Preheat length and mode are unchanged.
- R11: drive_en_o is 0 in the cycle after any cycle with thermal_fault high. It returns to 1 once the fault clears, without changing mode_o.
- R12: After supply_ok falls and rises again, the sequence restarts from preheat with the ramp at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good level, hysteresis applied outside |
| ext_shutdown | input | 1 | External request to pull the ramp to zero |
| zvs_pulldown | input | 1 | ZVS-failure request lowering the ramp |
| thermal_fault | input | 1 | Over-temperature flag |
| mode_o | output | 5 | One-hot mode: preheat, ignition, run, active ZVS, shutdown (bits 0..4) |
| freq_word_o | output | FW_W | Oscillator frequency control word |
| dead_sel_o | output | DT_W | Dead-time select, all ones is longest |
| drive_en_o | output | 1 | Gate drive enable |

## Verification
Ramp and latch state change on the clock edge that samples an input or a prescaler tick. The four outputs are registered from that state, so they follow one edge later. A mode threshold crossed at edge k therefore shows in mode_o after edge k+1. An ext_shutdown pulse sampled at edge a clears the ramp at a, sets the latch at a+1, and shows shutdown after a+2. The bench keeps a model that is advanced on the same edges and carries the same one-register lag. Every output is compared at the falling edge, where both are settled. Directed checks then count the cycles each mode is shown against the R2, R3 and R5 formulas.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef logic [4:0] mode_t;

  localparam int BIT_PRE  = 0;
  localparam int BIT_IGN  = 1;
  localparam int BIT_RUN  = 2;
  localparam int BIT_ZVS  = 3;
  localparam int BIT_SHUT = 4;

  localparam mode_t MODE_IDLE = 5'b00000;
  localparam mode_t MODE_PRE  = 5'b00001;
  localparam mode_t MODE_IGN  = 5'b00010;
  localparam mode_t MODE_RUN  = 5'b00100;
  localparam mode_t MODE_ZVS  = 5'b01000;
  localparam mode_t MODE_SHUT = 5'b10000;
endpackage

// File: rtl/ballast_ramp.sv
module ballast_ramp #(
  parameter int RAMP_W   = 10,
  parameter int PRESCALE = 16,
  parameter int IGN_MULT = 6,
  parameter int TH_SHUT  = 250,
  parameter int TH_IGN   = 375,
  parameter int TH_RUN   = 625,
  parameter int TH_ZVS   = 750
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              ext_shutdown,
  input  logic              zvs_pulldown,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              ign_done_o,
  output logic              azvs_o,
  output logic              shut_o
);
  localparam logic [RAMP_W-1:0] R_SHUT = RAMP_W'(TH_SHUT);
  localparam logic [RAMP_W-1:0] R_IGN  = RAMP_W'(TH_IGN);
  localparam logic [RAMP_W-1:0] R_RUN  = RAMP_W'(TH_RUN);
  localparam logic [RAMP_W-1:0] R_ZVS  = RAMP_W'(TH_ZVS);
  localparam logic [RAMP_W-1:0] R_MAX  = '1;
  localparam logic [RAMP_W:0]   R_STEP = (RAMP_W+1)'(IGN_MULT);

  logic tick;

  generate
    if (PRESCALE <= 1) begin : g_notick
      assign tick = supply_ok;
    end else begin : g_presc
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !supply_ok)              cnt <= '0;
        else if (cnt == PW'(PRESCALE - 1))  cnt <= '0;
        else                                cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == PW'(PRESCALE - 1));
    end
  endgenerate

  logic [RAMP_W-1:0] ramp;
  logic              ign_done, azvs, shut;
  logic [RAMP_W:0]   ign_sum;

  assign ign_sum = {1'b0, ramp} + R_STEP;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      ramp     <= '0;
      ign_done <= 1'b0;
      azvs     <= 1'b0;
      shut     <= 1'b0;
    end else if (!shut) begin
      if (!ign_done) begin
        if (ramp >= R_RUN) begin
          ign_done <= 1'b1;
        end else if (tick) begin
          if (ramp < R_IGN)                   ramp <= ramp + 1'b1;
          else if (ign_sum >= {1'b0, R_RUN})  ramp <= R_RUN;
          else                                ramp <= ign_sum[RAMP_W-1:0];
        end
      end else if (!azvs) begin
        if (ramp >= R_ZVS)  azvs <= 1'b1;
        else if (tick)      ramp <= ramp + 1'b1;
      end else begin
        if (ramp < R_SHUT) begin
          shut <= 1'b1;
        end else if (ext_shutdown) begin
          ramp <= '0;
        end else if (tick) begin
          if (zvs_pulldown)        ramp <= ramp - 1'b1;
          else if (ramp != R_MAX)  ramp <= ramp + 1'b1;
        end
      end
    end
  end

  assign ramp_o     = ramp;
  assign ign_done_o = ign_done;
  assign azvs_o     = azvs;
  assign shut_o     = shut;

  p_ign_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ign_done && supply_ok) |=> ign_done);

  p_shut_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (shut && supply_ok) |=> shut);

  p_azvs_after_ign_r6: assert property (@(posedge clk) disable iff (rst)
    azvs |-> ign_done);

  p_ramp_slope_r3: assert property (@(posedge clk) disable iff (rst)
    supply_ok |=> ((RAMP_W+1)'(ramp) <= (RAMP_W+1)'($past(ramp)) + R_STEP));
endmodule

// File: rtl/ballast_freq.sv
module ballast_freq
  import ballast_pkg::*;
#(
  parameter int RAMP_W = 10,
  parameter int FW_W   = 16,
  parameter int F_RUN  = 1000,
  parameter int TH_IGN = 375,
  parameter int TH_RUN = 625
) (
  input  logic [RAMP_W-1:0] ramp,
  input  mode_t             mode,
  output logic [FW_W-1:0]   fword
);
  localparam int SPAN     = TH_RUN - TH_IGN;
  localparam int PRE_WORD = (F_RUN * 8) / 5;
  localparam logic [RAMP_W-1:0] R_RUN = RAMP_W'(TH_RUN);

  logic [31:0] gap, extra;

  always_comb begin
    gap   = (ramp < R_RUN) ? (32'(TH_RUN) - 32'(ramp)) : 32'd0;
    extra = (32'(F_RUN) * 32'd3 * gap) / 32'(5 * SPAN);
    case (mode)
      MODE_PRE:           fword = FW_W'(PRE_WORD);
      MODE_IGN:           fword = FW_W'(32'(F_RUN) + extra);
      MODE_RUN, MODE_ZVS: fword = FW_W'(F_RUN);
      default:            fword = '0;
    endcase
  end
endmodule

// File: rtl/ballast_dtsel.sv
module ballast_dtsel
  import ballast_pkg::*;
#(
  parameter int RAMP_W  = 10,
  parameter int DT_W    = 3,
  parameter int TH_IGN  = 375,
  parameter int DT_STEP = 64
) (
  input  logic [RAMP_W-1:0] ramp,
  input  mode_t             mode,
  output logic [DT_W-1:0]   dsel
);
  localparam int DT_MAX = (1 << DT_W) - 1;
  localparam logic [RAMP_W-1:0] R_IGN  = RAMP_W'(TH_IGN);
  localparam logic [RAMP_W-1:0] R_STEP = RAMP_W'(DT_STEP);
  localparam logic [RAMP_W-1:0] R_DTM  = RAMP_W'(DT_MAX);

  logic [RAMP_W-1:0] above, steps, mapped;

  always_comb begin
    above  = (ramp >= R_IGN) ? (ramp - R_IGN) : '0;
    steps  = above / R_STEP;
    mapped = (steps >= R_DTM) ? '0 : (R_DTM - steps);
    case (mode)
      MODE_IGN, MODE_RUN, MODE_ZVS: dsel = mapped[DT_W-1:0];
      default:                      dsel = DT_W'(DT_MAX);
    endcase
  end
endmodule

// File: rtl/ballast_startup_seq.sv
module ballast_startup_seq
  import ballast_pkg::*;
#(
  parameter int RAMP_W   = 10,
  parameter int PRESCALE = 16,
  parameter int IGN_MULT = 6,
  parameter int TH_SHUT  = 250,
  parameter int TH_IGN   = 375,
  parameter int TH_RUN   = 625,
  parameter int TH_ZVS   = 750,
  parameter int FW_W     = 16,
  parameter int F_RUN    = 1000,
  parameter int DT_W     = 3,
  parameter int DT_STEP  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            supply_ok,
  input  logic            ext_shutdown,
  input  logic            zvs_pulldown,
  input  logic            thermal_fault,
  output logic [4:0]      mode_o,
  output logic [FW_W-1:0] freq_word_o,
  output logic [DT_W-1:0] dead_sel_o,
  output logic            drive_en_o
);
  localparam logic [RAMP_W-1:0] R_IGN = RAMP_W'(TH_IGN);

  logic [RAMP_W-1:0] ramp;
  logic              ign_done, azvs, shut;
  mode_t             mode_d;
  logic [FW_W-1:0]   fword_d;
  logic [DT_W-1:0]   dsel_d;
  logic              drive_d;

  ballast_ramp #(
    .RAMP_W(RAMP_W), .PRESCALE(PRESCALE), .IGN_MULT(IGN_MULT),
    .TH_SHUT(TH_SHUT), .TH_IGN(TH_IGN), .TH_RUN(TH_RUN), .TH_ZVS(TH_ZVS)
  ) u_ramp (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .ext_shutdown(ext_shutdown), .zvs_pulldown(zvs_pulldown),
    .ramp_o(ramp), .ign_done_o(ign_done), .azvs_o(azvs), .shut_o(shut)
  );

  always_comb begin
    if (!supply_ok)        mode_d = MODE_IDLE;
    else if (shut)         mode_d = MODE_SHUT;
    else if (azvs)         mode_d = MODE_ZVS;
    else if (ign_done)     mode_d = MODE_RUN;
    else if (ramp >= R_IGN) mode_d = MODE_IGN;
    else                   mode_d = MODE_PRE;
  end

  ballast_freq #(
    .RAMP_W(RAMP_W), .FW_W(FW_W), .F_RUN(F_RUN), .TH_IGN(TH_IGN), .TH_RUN(TH_RUN)
  ) u_freq (
    .ramp(ramp), .mode(mode_d), .fword(fword_d)
  );

  ballast_dtsel #(
    .RAMP_W(RAMP_W), .DT_W(DT_W), .TH_IGN(TH_IGN), .DT_STEP(DT_STEP)
  ) u_dtsel (
    .ramp(ramp), .mode(mode_d), .dsel(dsel_d)
  );

  assign drive_d = supply_ok && !shut && !thermal_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o      <= MODE_IDLE;
      freq_word_o <= '0;
      dead_sel_o  <= '1;
      drive_en_o  <= 1'b0;
    end else begin
      mode_o      <= mode_d;
      freq_word_o <= fword_d;
      dead_sel_o  <= dsel_d;
      drive_en_o  <= drive_d;
    end
  end

  p_mode_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mode_o));

  p_idle_nodrive_r1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!drive_en_o && mode_o == MODE_IDLE));

  p_shut_nodrive_r9: assert property (@(posedge clk) disable iff (rst)
    mode_o[BIT_SHUT] |-> (!drive_en_o && freq_word_o == '0));

  p_thermal_cut_r11: assert property (@(posedge clk) disable iff (rst)
    thermal_fault |=> !drive_en_o);
endmodule

// File: tb/ballast_startup_seq_test.sv
module ballast_startup_seq_test;
  localparam int RW  = 10;
  localparam int PS  = 4;
  localparam int IG  = 6;
  localparam int L2  = 250;
  localparam int L3  = 375;
  localparam int L5  = 625;
  localparam int L6  = 750;
  localparam int FW  = 16;
  localparam int FR  = 1000;
  localparam int DW  = 3;
  localparam int DS  = 64;
  localparam int DTM = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply = 1'b0;
  logic ext_sd = 1'b0;
  logic pull = 1'b0;
  logic therm = 1'b0;
  logic [4:0]    mode;
  logic [FW-1:0] fword;
  logic [DW-1:0] dsel;
  logic          drive;

  always #4 clk = ~clk;

  ballast_startup_seq #(
    .RAMP_W(RW), .PRESCALE(PS), .IGN_MULT(IG), .TH_SHUT(L2), .TH_IGN(L3),
    .TH_RUN(L5), .TH_ZVS(L6), .FW_W(FW), .F_RUN(FR), .DT_W(DW), .DT_STEP(DS)
  ) uut (
    .clk(clk), .rst(rst), .supply_ok(supply), .ext_shutdown(ext_sd),
    .zvs_pulldown(pull), .thermal_fault(therm), .mode_o(mode),
    .freq_word_o(fword), .dead_sel_o(dsel), .drive_en_o(drive)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  int m_p = 0, m_r = 0;
  bit m_d = 0, m_a = 0, m_s = 0;
  int e_mode = 0, e_fw = 0, e_dt = DTM;
  bit e_drv = 0;

  function automatic int dt_of(input int r);
    int s;
    if (r < L3) return DTM;
    s = (r - L3) / DS;
    return (s >= DTM) ? 0 : DTM - s;
  endfunction

  always @(posedge clk) begin
    int md;
    if (!supply)     md = 0;
    else if (m_s)    md = 16;
    else if (m_a)    md = 8;
    else if (m_d)    md = 4;
    else if (m_r >= L3) md = 2;
    else             md = 1;
    if (rst) begin
      e_mode <= 0; e_fw <= 0; e_dt <= DTM; e_drv <= 0;
    end else begin
      e_mode <= md;
      case (md)
        1:       e_fw <= FR * 8 / 5;
        2:       e_fw <= FR + (3 * FR * ((m_r < L5) ? (L5 - m_r) : 0)) / (5 * (L5 - L3));
        4, 8:    e_fw <= FR;
        default: e_fw <= 0;
      endcase
      e_dt  <= (md == 2 || md == 4 || md == 8) ? dt_of(m_r) : DTM;
      e_drv <= supply && !m_s && !therm;
    end
    if (rst || !supply) begin
      m_p <= 0; m_r <= 0; m_d <= 0; m_a <= 0; m_s <= 0;
    end else begin
      bit tk;
      tk = (m_p == PS - 1);
      m_p <= tk ? 0 : m_p + 1;
      if (!m_s) begin
        if (!m_d) begin
          if (m_r >= L5) m_d <= 1;
          else if (tk) m_r <= (m_r < L3) ? m_r + 1 : ((m_r + IG >= L5) ? L5 : m_r + IG);
        end else if (!m_a) begin
          if (m_r >= L6) m_a <= 1;
          else if (tk) m_r <= m_r + 1;
        end else begin
          if (m_r < L2) m_s <= 1;
          else if (ext_sd) m_r <= 0;
          else if (tk) begin
            if (pull) m_r <= m_r - 1;
            else if (m_r != (1 << RW) - 1) m_r <= m_r + 1;
          end
        end
      end
    end
  end

  function automatic string mode_tag(input int m);
    case (m)
      1: return "R2";
      2: return "R3";
      4: return "R5";
      8: return "R6";
      16: return "R9";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(int'(mode) == e_mode, mode_tag(e_mode), int'(mode), e_mode);
      chk(int'(fword) == e_fw, "R4", int'(fword), e_fw);
      chk(int'(dsel) == e_dt, "R7", int'(dsel), e_dt);
      chk(drive == e_drv, "R11", int'(drive), int'(e_drv));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int cnt, dt_start, guard;
    bit saw_ign;
    step(3);
    rst = 1'b0;
    step(1);
    cmp_on = 1'b1;
    step(2);
    // R1 idle state
    chk(mode == 5'b0, "R1", int'(mode), 0);
    chk(drive == 1'b0, "R1", int'(drive), 0);
    chk(fword == '0, "R1", int'(fword), 0);
    chk(int'(dsel) == DTM, "R1", int'(dsel), DTM);

    // R2 and R10: preheat with both requests held, must be ignored
    supply = 1'b1; ext_sd = 1'b1; pull = 1'b1;
    step(1);
    cnt = 0;
    while (mode == 5'b00001) begin cnt++; step(1); end
    ext_sd = 1'b0; pull = 1'b0;
    chk(cnt == L3 * PS, "R2", cnt, L3 * PS);
    chk(cnt == L3 * PS, "R10", cnt, L3 * PS);

    // R3 and R4: ignition length and frequency sweep endpoints
    chk(int'(fword) == FR * 8 / 5, "R4", int'(fword), FR * 8 / 5);
    cnt = 0;
    while (mode == 5'b00010) begin cnt++; step(1); end
    chk(cnt == ((L5 - L3 + IG - 1) / IG) * PS + 1, "R3", cnt, ((L5 - L3 + IG - 1) / IG) * PS + 1);

    // R5: run window
    cnt = 0;
    while (mode == 5'b00100) begin
      cnt++;
      chk(int'(fword) == FR, "R5", int'(fword), FR);
      step(1);
    end
    chk(cnt == (L6 - L5) * PS, "R5", cnt, (L6 - L5) * PS);
    chk(mode == 5'b01000, "R6", int'(mode), 8);
    dt_start = int'(dsel);

    // R11: thermal fault, non-latching
    therm = 1'b1; step(2);
    chk(drive == 1'b0, "R11", int'(drive), 0);
    chk(mode == 5'b01000, "R11", int'(mode), 8);
    therm = 1'b0; step(2);
    chk(drive == 1'b1, "R11", int'(drive), 1);

    // R8 and R7: pull the ramp back into the ignition window
    pull = 1'b1;
    saw_ign = 1'b0;
    for (int i = 0; i < (L6 - (L3 + L5) / 2) * PS; i++) begin
      step(1);
      if (mode[1] || mode[0]) saw_ign = 1'b1;
    end
    pull = 1'b0;
    step(2);
    chk(!saw_ign, "R8", int'(saw_ign), 0);
    chk(mode == 5'b01000, "R8", int'(mode), 8);
    chk(int'(dsel) > dt_start, "R7", int'(dsel), dt_start + 1);

    // R9: external shutdown pulse, then latched
    ext_sd = 1'b1; step(1); ext_sd = 1'b0;
    step(2);
    chk(mode == 5'b10000, "R9", int'(mode), 16);
    chk(drive == 1'b0, "R9", int'(drive), 0);
    step(50);
    chk(mode == 5'b10000, "R9", int'(mode), 16);
    chk(fword == '0, "R9", int'(fword), 0);

    // R12: supply drop clears, restart from preheat
    supply = 1'b0; step(2);
    chk(mode == 5'b0, "R1", int'(mode), 0);
    supply = 1'b1; step(2);
    chk(mode == 5'b00001, "R12", int'(mode), 1);
    chk(int'(fword) == FR * 8 / 5, "R12", int'(fword), FR * 8 / 5);

    // R9: ZVS-failure path pulls the ramp down to shutdown
    guard = 0;
    while (mode != 5'b01000 && guard < 5000) begin guard++; step(1); end
    chk(mode == 5'b01000, "R6", int'(mode), 8);
    pull = 1'b1;
    guard = 0;
    while (mode != 5'b10000 && guard < (L6 - L2 + 4) * PS) begin guard++; step(1); end
    pull = 1'b0;
    chk(mode == 5'b10000, "R9", int'(mode), 16);
    step(4);
    chk(drive == 1'b0, "R9", int'(drive), 0);

    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule